// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block connects a simple synchronous host request port to a 1M x 16 asynchronous EDO DRAM. The host offers one request at a time: a 20-bit word address, a read/write flag, 16-bit write data and two byte enables, accepted on a valid/ready handshake. Reads come back on a data bus that is qualified by a one-cycle valid strobe. The controller splits the address into a 10-bit row (upper bits) and a 10-bit column (lower bits). It multiplexes these onto the 10 DRAM address pins and sequences the row strobe, the two column strobes (one per byte lane), write enable and output enable. Every wait is a cycle count derived from nanosecond parameters and a clock-period parameter, each rounded up.

After an access the row stays open. A later request to the same row is served as a column-only page cycle. A request to another row first precharges and then opens the new row. A free-running timer raises a refresh request about every 15.6 us. The controller finishes the access in flight, closes any open page, and performs a CAS-before-RAS refresh before it takes the next host request.

States: `ST_IDLE` (precharged, no row open), `ST_ROW` (row strobe low, row address out), `ST_SETUP` (column address and write enable set up, column strobes high), `ST_COL` (column strobes low), `ST_CPRE` (column precharge, row held), `ST_OPEN` (page open, waiting), `ST_PRE` (row precharge), `ST_REF_CAS`, `ST_REF_RAS` and `ST_REF_PRE` (the three refresh phases). The transitions are as follows:
- IDLE goes to REF_CAS when a refresh is due, or to ROW on an accepted request.
- ROW goes to SETUP, then COL, then CPRE, then OPEN, each after its count.
- OPEN goes to PRE when a refresh is due or on a row miss, and to SETUP on a row hit.
- PRE goes to ROW if a miss request is pending, otherwise to IDLE.
- REF_CAS goes to REF_RAS, then REF_PRE, then IDLE.

Top module: `edo_ctrl`

## Requirements
- R1: A host address drives its bits 19:10 onto the DRAM address pins when the row strobe falls and its bits 9:0 when a column strobe falls, so word N of the host is word N of the DRAM.
- R2: Byte enable bit 1 lowers the upper column strobe (data bits 15:8) and bit 0 lowers the lower column strobe (bits 7:0); a write changes only the enabled lanes.
- R3: A read returns the addressed word on rsp_rdata with rsp_valid high for exactly one cycle; the data is sampled after the column strobe has been low for the column access count.
- R4: A request whose row equals the open row is served without the row strobe rising again.
- R5: A request to a different row raises the row strobe and keeps it high for at least the precharge count before opening the new row.
- R6: Refresh lowers both column strobes while the row strobe is high and only then lowers the row strobe; one refresh is issued per refresh interval.
- R7: While a refresh is due or running, req_ready is low; a pending refresh closes an open page, so the next access to that row opens it again.
- R8: Output enable is low only during the column phase of a read, never while the controller drives the data bus.
- R9: On a write, write enable is already low in the cycle before a column strobe falls.
- R10: During and right after reset, all strobes, write enable and output enable are high, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in 19:10, column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | 16 | Data returned from the DRAM |

## Verification
The bench targets page hits just after a refresh, where a controller that forgot the open row would lower the row strobe again and lose the page benefit. It also aims a read at a row that was open when a refresh fell due; a controller that failed to close the page would skip reopening the row and read from a row the DRAM no longer holds open. Single-lane writes catch swapped or merged column strobes, which would corrupt the other byte. A behavioural memory flags short precharge, short column pulses, short page cycles, late write enable and bus contention, any of which a wrong count or a state that skipped a phase would produce.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_SETUP,
        ST_COL,
        ST_CPRE,
        ST_OPEN,
        ST_PRE,
        ST_REF_CAS,
        ST_REF_RAS,
        ST_REF_PRE
    } edo_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/edo_delay.sv
module edo_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int PERIOD = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] tick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
            due  <= 1'b0;
        end else begin
            tick <= (tick == LAST) ? '0 : tick + 1'b1;
            if (tick == LAST) due <= 1'b1;
            else if (ack)     due <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int T_RP_NS   = 30,
    parameter int T_RCD_NS  = 20,
    parameter int T_CAA_NS  = 25,
    parameter int T_CP_NS   = 10,
    parameter int T_CSR_NS  = 10,
    parameter int T_RAS_NS  = 50,
    parameter int T_REF_NS  = 15600,
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DQ_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    input  logic [1:0]             req_be,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_rdata,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_ucas_n,
    output logic                   dram_lcas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);
    localparam int AW    = ROW_W + COL_W;
    localparam int DW    = 8;
    localparam int N_RP  = ns2cyc(T_RP_NS,  CLK_NS);
    localparam int N_RCD = ns2cyc(T_RCD_NS, CLK_NS);
    localparam int N_CAS = ns2cyc(T_CAA_NS, CLK_NS);
    localparam int N_CP  = ns2cyc(T_CP_NS,  CLK_NS);
    localparam int N_CSR = ns2cyc(T_CSR_NS, CLK_NS);
    localparam int N_RAS = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int N_REF = ns2cyc(T_REF_NS, CLK_NS);

    edo_state_e         state, nstate;
    logic               ref_due, ref_ack;
    logic               wait_done, wait_load;
    logic [DW-1:0]      wait_val;
    logic               req_fire, row_hit;
    logic               pend;
    logic [AW-1:0]      lat_addr;
    logic               lat_we;
    logic [1:0]         lat_be;
    logic [DQ_W-1:0]    lat_wdata;
    logic [ROW_W-1:0]   open_row;

    edo_refresh_timer #(.PERIOD(N_REF)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
    );

    edo_delay #(.W(DW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(wait_load), .val(wait_val), .done(wait_done)
    );

    assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_due;
    assign req_fire  = req_valid && req_ready;
    assign row_hit   = (req_addr[AW-1:COL_W] == open_row);
    assign ref_ack   = (state == ST_IDLE) && ref_due;

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (ref_due) nstate = ST_REF_CAS;
                        else if (req_fire) nstate = ST_ROW;
            ST_ROW:     if (wait_done) nstate = ST_SETUP;
            ST_SETUP:   nstate = ST_COL;
            ST_COL:     if (wait_done) nstate = ST_CPRE;
            ST_CPRE:    if (wait_done) nstate = ST_OPEN;
            ST_OPEN:    if (ref_due) nstate = ST_PRE;
                        else if (req_fire) nstate = row_hit ? ST_SETUP : ST_PRE;
            ST_PRE:     if (wait_done) nstate = pend ? ST_ROW : ST_IDLE;
            ST_REF_CAS: if (wait_done) nstate = ST_REF_RAS;
            ST_REF_RAS: if (wait_done) nstate = ST_REF_PRE;
            ST_REF_PRE: if (wait_done) nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // Dwell count for the state being entered
    always_comb begin
        wait_load = (nstate != state);
        unique case (nstate)
            ST_ROW:             wait_val = DW'(N_RCD - 1);
            ST_COL:             wait_val = DW'(N_CAS - 1);
            ST_CPRE:            wait_val = DW'(N_CP - 1);
            ST_PRE, ST_REF_PRE: wait_val = DW'(N_RP - 1);
            ST_REF_CAS:         wait_val = DW'(N_CSR - 1);
            ST_REF_RAS:         wait_val = DW'(N_RAS - 1);
            default:            wait_val = '0;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend      <= 1'b0;
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_be    <= '0;
            lat_wdata <= '0;
            open_row  <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= nstate;
            rsp_valid <= 1'b0;
            if (req_fire) begin
                lat_addr  <= req_addr;
                lat_we    <= req_write;
                lat_be    <= req_be;
                lat_wdata <= req_wdata;
                pend      <= (state == ST_OPEN) && !row_hit;
            end
            if (nstate == ST_ROW && state != ST_ROW) begin
                pend     <= 1'b0;
                open_row <= (state == ST_IDLE) ? req_addr[AW-1:COL_W]
                                               : lat_addr[AW-1:COL_W];
            end
            if (state == ST_COL && wait_done && !lat_we) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= dram_dq_in;
            end
        end
    end

    // DRAM pin decode
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_ucas_n = 1'b1;
        dram_lcas_n = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_addr   = lat_addr[AW-1:COL_W];
        dram_dq_out = lat_wdata;
        unique case (state)
            ST_ROW, ST_CPRE, ST_OPEN, ST_REF_RAS: dram_ras_n = 1'b0;
            ST_SETUP: begin
                dram_ras_n = 1'b0;
                dram_addr  = lat_addr[COL_W-1:0];
                dram_we_n  = !lat_we;
                dram_dq_oe = lat_we;
            end
            ST_COL: begin
                dram_ras_n  = 1'b0;
                dram_addr   = lat_addr[COL_W-1:0];
                dram_ucas_n = !lat_be[1];
                dram_lcas_n = !lat_be[0];
                dram_we_n   = !lat_we;
                dram_dq_oe  = lat_we;
                dram_oe_n   = lat_we;
            end
            default: ;
        endcase
        if (state == ST_REF_CAS || state == ST_REF_RAS) begin
            dram_ucas_n = 1'b0;
            dram_lcas_n = 1'b0;
        end
        if (state == ST_REF_RAS) dram_ras_n = 1'b0;
    end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int N_RP = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic ucas_n,
    input logic lcas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic rsp_valid,
    input logic req_ready,
    input logic ref_due
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= 8'd0;
        else if (!ras_n)     hi_cnt <= 8'd0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
    end

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && we_n));                                     // R8
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !(ucas_n && lcas_n)) |-> $past(!ucas_n && !lcas_n)); // R6
    AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(ucas_n) || $fell(lcas_n)) && !we_n) |-> $past(!we_n));   // R9
    AST_NO_READY_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_due |-> !req_ready);                                         // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                       // R3
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= 8'(N_RP)));                          // R5
endmodule

bind edo_ctrl edo_ctrl_chk #(.N_RP(N_RP)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .ucas_n(dram_ucas_n),
    .lcas_n(dram_lcas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .dq_oe(dram_dq_oe), .rsp_valid(rsp_valid), .req_ready(req_ready),
    .ref_due(ref_due)
);

// File: tb/edo_ctrl_tb.sv
module edo_ctrl_tb;
    localparam int CLK_NS = 8;
    localparam int REF_NS = 4000;
    localparam int REF_CYC = REF_NS / CLK_NS;
    localparam int MIN_RP  = 4;   // 30 ns at 8 ns
    localparam int MIN_CAS = 4;   // 25 ns column access at 8 ns
    localparam int MIN_PC  = 3;   // 20 ns page cycle at 8 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [9:0]  dram_addr;
    logic        ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
    logic [15:0] dq_out;
    logic [15:0] dq_in = '0;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    edo_ctrl #(.CLK_NS(CLK_NS), .T_REF_NS(REF_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_ucas_n(ucas_n),
        .dram_lcas_n(lcas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    // Behavioural EDO memory with timing checks
    logic [15:0] mem [int];
    logic [9:0]  m_row = '0, m_col = '0;
    logic        p_ras = 1'b1, p_ucas = 1'b1, p_lcas = 1'b1, p_we = 1'b1;
    int ras_hi = 100, cas_lo = 0, since_cas = 100;
    int ras_falls = 0, ref_cnt = 0;
    int v_prech = 0, v_cas = 0, v_pc = 0, v_we = 0, v_bus = 0, v_rdy = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                ras_falls++;
                if (!ucas_n || !lcas_n) ref_cnt++;
                else m_row = dram_addr;
                if (ras_hi < MIN_RP) v_prech++;
            end
            if (!ras_n && ((p_ucas && !ucas_n) || (p_lcas && !lcas_n))) begin
                m_col = dram_addr;
                if (since_cas < MIN_PC) v_pc++;
                since_cas = 0;
                if (!we_n) begin
                    logic [15:0] w;
                    w = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 16'h0;
                    if (!p_we) ; else v_we++;
                    if (!dq_oe) v_bus++;
                    if (!ucas_n) w[15:8] = dq_out[15:8];
                    if (!lcas_n) w[7:0]  = dq_out[7:0];
                    mem[{m_row, m_col}] = w;
                end
            end
            if (ras_n == 1'b0 && (!p_ucas || !p_lcas) && ucas_n && lcas_n && !p_we == 1'b0
                && cas_lo < MIN_CAS) v_cas++;
            if (!oe_n && dq_oe) v_bus++;
            if (ras_n && !(ucas_n && lcas_n) && req_ready) v_rdy++;
            cas_lo    = (!ucas_n || !lcas_n) ? cas_lo + 1 : 0;
            ras_hi    = ras_n ? ras_hi + 1 : 0;
            since_cas = since_cas + 1;
            dq_in = 16'h0;
            if (!ras_n && !oe_n && we_n && mem.exists({m_row, m_col})) begin
                if (!ucas_n) dq_in[15:8] = mem[{m_row, m_col}][15:8];
                if (!lcas_n) dq_in[7:0]  = mem[{m_row, m_col}][7:0];
            end
            p_ras = ras_n; p_ucas = ucas_n; p_lcas = lcas_n; p_we = we_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        send(1'b1, a, d, be);
        repeat (12) @(negedge clk);
    endtask

    task automatic do_read(input logic [19:0] a, input logic [1:0] be, output logic [15:0] d);
        int n;
        send(1'b0, a, 16'h0, be);
        n = 0;
        while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
        d = rsp_rdata;
        @(negedge clk);
        check(!rsp_valid, "R3 pulse", int'(rsp_valid), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_refresh();
        int r;
        r = ref_cnt;
        while (ref_cnt == r) @(negedge clk);
        repeat (15) @(negedge clk);
    endtask

    task automatic t_reset();
        check(ras_n && ucas_n && lcas_n, "R10 strobes", {ras_n, ucas_n, lcas_n}, 3'b111);
        check(we_n && oe_n, "R10 we/oe", {we_n, oe_n}, 2'b11);
        check(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
    endtask

    task automatic t_rw();
        logic [15:0] d;
        logic [19:0] addrs [4] = '{20'h00000, 20'hFFFFF, 20'h2A155, 20'h803FF};
        logic [15:0] data  [4] = '{16'h1234, 16'hBEEF, 16'h5AA5, 16'h0F0F};
        for (int i = 0; i < 4; i++) begin
            wait_refresh();
            do_write(addrs[i], data[i], 2'b11);
            check(mem.exists(int'(addrs[i])) && mem[int'(addrs[i])] == data[i], "R1 split",
                  mem.exists(int'(addrs[i])) ? int'(mem[int'(addrs[i])]) : -1, int'(data[i]));
            do_read(addrs[i], 2'b11, d);
            check(d == data[i], "R3 read data", int'(d), int'(data[i]));
        end
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        wait_refresh();
        do_write(20'h12345, 16'hFFFF, 2'b11);
        do_write(20'h12345, 16'hA1B2, 2'b10);
        check(mem[int'(20'h12345)] == 16'hA1FF, "R2 upper lane", int'(mem[int'(20'h12345)]), 16'hA1FF);
        do_write(20'h12345, 16'hC3D4, 2'b01);
        check(mem[int'(20'h12345)] == 16'hA1D4, "R2 lower lane", int'(mem[int'(20'h12345)]), 16'hA1D4);
        do_read(20'h12345, 2'b01, d);
        check(d[7:0] == 8'hD4, "R2 lower read", int'(d[7:0]), 8'hD4);
    endtask

    task automatic t_hit();
        logic [15:0] d;
        int rf;
        wait_refresh();
        do_write({10'h155, 10'h001}, 16'h1111, 2'b11);
        rf = ras_falls;
        do_write({10'h155, 10'h002}, 16'h2222, 2'b11);
        do_read({10'h155, 10'h001}, 2'b11, d);
        check(ras_falls == rf, "R4 no RAS on hit", ras_falls - rf, 0);
        check(d == 16'h1111, "R4 hit data", int'(d), 16'h1111);
        do_read({10'h0AA, 10'h002}, 2'b11, d);
        check(ras_falls == rf + 1, "R5 miss reopens", ras_falls - rf, 1);
        check(v_prech == 0, "R5 precharge", v_prech, 0);
    endtask

    task automatic t_refresh();
        int rc;
        rc = ref_cnt;
        repeat (10 * REF_CYC) @(negedge clk);
        check(ref_cnt - rc >= 9 && ref_cnt - rc <= 11, "R6 refresh rate", ref_cnt - rc, 10);
    endtask

    task automatic t_preempt();
        logic [15:0] d;
        int rf, r;
        wait_refresh();
        do_write({10'h321, 10'h010}, 16'h7E7E, 2'b11);
        r = ref_cnt;
        while (ref_cnt == r) @(negedge clk);
        repeat (15) @(negedge clk);
        rf = ras_falls;
        do_read({10'h321, 10'h010}, 2'b11, d);
        check(ras_falls == rf + 1, "R7 page closed by refresh", ras_falls - rf, 1);
        check(d == 16'h7E7E, "R7 data after refresh", int'(d), 16'h7E7E);
        check(v_rdy == 0, "R7 ready during refresh", v_rdy, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_bytes();
        t_hit();
        t_refresh();
        t_preempt();
        check(v_bus == 0, "R8 bus contention", v_bus, 0);
        check(v_we == 0, "R9 early write", v_we, 0);
        check(v_cas == 0 && v_pc == 0, "R3 column timing", v_cas + v_pc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule